// File: doc/BRIEF.md
# Low-Power Clock Divider and Wake Controller

This block lets a processor core run at a reduced rate and returns it to full speed when an interrupt arrives. A configuration write sets a five-bit divide value, a divide-by-16 prescale select, a low-power permission bit and a choice of recovery style. A single-cycle request then moves the block into low power. While in low power, the core sees a one-cycle clock-enable pulse at the divided rate. Outside low power, the enable is held high.

The block leaves low power when any of sixteen internal interrupt lines is raised. In gentle recovery, the core goes straight back to full rate and services the interrupt in the usual way. In hard recovery, the core is held in reset for a fixed 24 cycles at full rate. A power-on interrupt flag is then raised and stays set until it is acknowledged. Shared memory and peripherals are never reset by this block: only the core reset pin is driven.

A configuration written while low power is running takes effect at the next divider pulse. The period in progress always completes with the old settings.

Top module: `lp_clock_ctrl`

## Requirements
- R1: After reset, lp_active=0, cpu_ce=1, core_rst=0 and por_irq=0. The stored configuration is all zero, so a low-power request made before any write has no effect.
- R2: Whenever the block is not in low power, cpu_ce is 1 on every cycle.
- R3: lp_req enters low power on the next cycle only if the stored cfg_en bit is 1. With cfg_en=0, the request is ignored.
- R4: With cfg_pre16=0, cpu_ce pulses once every 2*(cfg_div+1) cycles. The first pulse falls in cycle 2*(cfg_div+1)-1, counting the first low-power cycle as cycle 0.
- R5: With cfg_pre16=1, the period is 32*(cfg_div+1) cycles, with the same phase rule as R4.
- R6: A configuration write made during low power leaves the current period unchanged. The new divide settings apply from the pulse that ends that period.
- R7: With cfg_destr=0, a 1 on any irq_src bit in low power gives lp_active=0 and cpu_ce=1 from the next cycle. core_rst stays 0 and por_irq is unchanged.
- R8: With cfg_destr=1, a wake interrupt drives core_rst high from the next cycle for exactly 24 cycles, with cpu_ce=1 throughout. por_irq is set when core_rst falls.
- R9: por_irq stays 1 until a cycle with por_clr=1, and is 0 after that cycle.
- R10: If cfg_en is written to 0 during low power, the block returns to full rate on the cycle after the next divider pulse, without asserting core_rst.
- R11: irq_src has no effect outside low power: core_rst, por_irq and lp_active do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| cfg_wr | input | 1 | Writes all configuration fields in this cycle |
| cfg_div | input | 5 | Divide value; the divider uses value+1 |
| cfg_pre16 | input | 1 | 1 = divider input is the main clock divided by 16 |
| cfg_en | input | 1 | 1 = low power permitted |
| cfg_destr | input | 1 | 1 = hard recovery (core reset), 0 = gentle recovery |
| lp_req | input | 1 | One-cycle request to enter low power |
| irq_src | input | 16 | Internal interrupt sources; any bit wakes the core |
| por_clr | input | 1 | Acknowledge that clears por_irq |
| cpu_ce | output | 1 | Core clock-enable strobe |
| lp_active | output | 1 | Low power in progress |
| core_rst | output | 1 | Core reset, driven during hard recovery |
| por_irq | output | 1 | Power-on interrupt flag |

## Verification
The divider chain can be out of step without any error flag, so the bench measures both the first and the second pulse after entry. A counter off by one shows up as a shifted pulse within one period, at most 1024 cycles. A fault in the wake state machine shows up on the cycle after the interrupt: either lp_active stays high or core_rst takes the wrong value. A fault in the reset timer shows up as a core_rst run that is not exactly 24 cycles long, or as a late or missing por_irq.

// File: rtl/lp_pkg.sv
package lp_pkg;
  localparam int LP_DIV_W = 5;

  typedef struct packed {
    logic                en;
    logic                destr;
    logic                pre16;
    logic [LP_DIV_W-1:0] div;
  } lp_cfg_t;

  typedef enum logic [1:0] {
    ST_FULL = 2'd0,
    ST_LOW  = 2'd1,
    ST_CRST = 2'd2
  } lp_state_e;
endpackage

// File: rtl/lp_cfg_reg.sv
module lp_cfg_reg
  import lp_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr,
  input  lp_cfg_t             wdata,
  input  logic                load,
  output lp_cfg_t             cur,
  output logic [LP_DIV_W-1:0] act_div,
  output logic                act_pre
);
  // cur is the written register; act_* is the copy the divider runs from
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur     <= '0;
      act_div <= '0;
      act_pre <= 1'b0;
    end else begin
      if (wr) cur <= wdata;
      if (load) begin
        act_div <= cur.div;
        act_pre <= cur.pre16;
      end
    end
  end
endmodule

// File: rtl/lp_clk_div.sv
module lp_clk_div
  import lp_pkg::*;
#(
  parameter int PRE_DIV = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic                pre_on,
  input  logic [LP_DIV_W-1:0] div_val,
  output logic                term
);
  logic                pre_tick;
  logic                half;
  logic                half_tick;
  logic [LP_DIV_W-1:0] div_cnt;

  generate
    if (PRE_DIV > 1) begin : g_pre
      localparam int PW = $clog2(PRE_DIV);
      logic [PW-1:0] pre_cnt;
      logic          pre_wrap;
      assign pre_wrap = (pre_cnt == PW'(PRE_DIV - 1));
      assign pre_tick = !pre_on || pre_wrap;
      always_ff @(posedge clk) begin
        if (!rst_n || !run) pre_cnt <= '0;
        else if (pre_on)    pre_cnt <= pre_wrap ? '0 : pre_cnt + 1'b1;
      end
    end else begin : g_nopre
      assign pre_tick = 1'b1;
    end
  endgenerate

  // fixed divide-by-two stage, then the programmable stage
  assign half_tick = pre_tick && half;
  assign term      = run && half_tick && (div_cnt == div_val);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      half    <= 1'b0;
      div_cnt <= '0;
    end else begin
      if (pre_tick)  half <= ~half;
      if (half_tick) div_cnt <= (div_cnt == div_val) ? '0 : div_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/lp_wake_fsm.sv
module lp_wake_fsm
  import lp_pkg::*;
#(
  parameter int NSRC       = 16,
  parameter int RST_CYCLES = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lp_req,
  input  logic            en_now,
  input  logic            destr,
  input  logic [NSRC-1:0] irq_src,
  input  logic            term,
  input  logic            por_clr,
  output logic            lp_active,
  output logic            core_rst,
  output logic            por_irq
);
  localparam int TW = $clog2(RST_CYCLES + 1);

  lp_state_e     state, state_nx;
  logic [TW-1:0] tmr;
  logic          tmr_last;

  assign tmr_last = (tmr == TW'(RST_CYCLES - 1));

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_FULL: if (lp_req && en_now) state_nx = ST_LOW;
      ST_LOW: begin
        if (|irq_src)             state_nx = destr ? ST_CRST : ST_FULL;
        else if (term && !en_now) state_nx = ST_FULL;
      end
      ST_CRST: if (tmr_last) state_nx = ST_FULL;
      default: state_nx = ST_FULL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_FULL;
      tmr     <= '0;
      por_irq <= 1'b0;
    end else begin
      state <= state_nx;
      tmr   <= (state == ST_CRST) ? tmr + 1'b1 : '0;
      if (state == ST_CRST && tmr_last) por_irq <= 1'b1;
      else if (por_clr)                 por_irq <= 1'b0;
    end
  end

  assign lp_active = (state == ST_LOW);
  assign core_rst  = (state == ST_CRST);
endmodule

// File: rtl/lp_clock_ctrl.sv
module lp_clock_ctrl
  import lp_pkg::*;
#(
  parameter int NSRC       = 16,
  parameter int PRE_DIV    = 16,
  parameter int RST_CYCLES = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_wr,
  input  logic [LP_DIV_W-1:0] cfg_div,
  input  logic                cfg_pre16,
  input  logic                cfg_en,
  input  logic                cfg_destr,
  input  logic                lp_req,
  input  logic [NSRC-1:0]     irq_src,
  input  logic                por_clr,
  output logic                cpu_ce,
  output logic                lp_active,
  output logic                core_rst,
  output logic                por_irq
);
  lp_cfg_t             wdata, cur;
  logic [LP_DIV_W-1:0] act_div;
  logic                act_pre;
  logic                term;
  logic                load;

  assign wdata = '{en: cfg_en, destr: cfg_destr, pre16: cfg_pre16, div: cfg_div};
  assign load  = !lp_active || term;

  lp_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .wdata(wdata), .load(load),
    .cur(cur), .act_div(act_div), .act_pre(act_pre)
  );

  lp_clk_div #(.PRE_DIV(PRE_DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .run(lp_active), .pre_on(act_pre),
    .div_val(act_div), .term(term)
  );

  lp_wake_fsm #(.NSRC(NSRC), .RST_CYCLES(RST_CYCLES)) u_fsm (
    .clk(clk), .rst_n(rst_n), .lp_req(lp_req), .en_now(cur.en),
    .destr(cur.destr), .irq_src(irq_src), .term(term), .por_clr(por_clr),
    .lp_active(lp_active), .core_rst(core_rst), .por_irq(por_irq)
  );

  assign cpu_ce = lp_active ? term : 1'b1;
endmodule

// File: rtl/lp_clock_ctrl_chk.sv
module lp_clock_ctrl_chk #(
  parameter int NSRC       = 16,
  parameter int RST_CYCLES = 24
) (
  input logic            clk,
  input logic            rst_n,
  input logic            lp_req,
  input logic [NSRC-1:0] irq_src,
  input logic            por_clr,
  input logic            cpu_ce,
  input logic            lp_active,
  input logic            core_rst,
  input logic            por_irq
);
  localparam int RW = $clog2(RST_CYCLES + 2);
  logic [RW-1:0] run;

  always_ff @(posedge clk) begin
    if (!rst_n)        run <= '0;
    else if (core_rst) run <= run + 1'b1;
    else               run <= '0;
  end

  a_r3_entry_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lp_active) |-> $past(lp_req));
  a_r4_ce_sparse: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_active && cpu_ce) |=> !(lp_active && cpu_ce));
  a_r7_wake_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_active && |irq_src) |=> !lp_active);
  a_r8_rst_full_speed: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst |-> (cpu_ce && !lp_active));
  a_r8_rst_bound: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst |-> (run < RW'(RST_CYCLES)));
  a_r8_por_after_rst: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_rst) |-> (run == RW'(RST_CYCLES) && por_irq));
  a_r9_por_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (por_irq && !por_clr) |=> por_irq);
  a_r11_no_rst_from_full: assert property (@(posedge clk) disable iff (!rst_n)
    (!lp_active && !core_rst) |=> !core_rst);
endmodule

bind lp_clock_ctrl lp_clock_ctrl_chk #(.NSRC(NSRC), .RST_CYCLES(RST_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .lp_req(lp_req), .irq_src(irq_src),
  .por_clr(por_clr), .cpu_ce(cpu_ce), .lp_active(lp_active),
  .core_rst(core_rst), .por_irq(por_irq)
);

// File: tb/lp_clock_ctrl_bench.sv
module lp_clock_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [4:0]  cfg_div = '0;
  logic        cfg_pre16 = 1'b0, cfg_en = 1'b0, cfg_destr = 1'b0;
  logic        lp_req = 1'b0;
  logic [15:0] irq_src = '0;
  logic        por_clr = 1'b0;
  logic        cpu_ce, lp_active, core_rst, por_irq;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  lp_clock_ctrl u_lp_clock_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_div(cfg_div),
    .cfg_pre16(cfg_pre16), .cfg_en(cfg_en), .cfg_destr(cfg_destr),
    .lp_req(lp_req), .irq_src(irq_src), .por_clr(por_clr), .cpu_ce(cpu_ce),
    .lp_active(lp_active), .core_rst(core_rst), .por_irq(por_irq)
  );

  // table: prescale, divide field, expected period in cycles
  localparam int NV = 7;
  localparam int V_PRE[NV] = '{0, 0, 0, 1, 1, 0, 1};
  localparam int V_DIV[NV] = '{0, 15, 31, 0, 3, 4, 31};
  localparam int V_PER[NV] = '{2, 32, 64, 32, 128, 10, 1024};

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic en, input logic destr, input logic pre,
                           input logic [4:0] dv);
    cfg_en = en; cfg_destr = destr; cfg_pre16 = pre; cfg_div = dv; cfg_wr = 1'b1;
    tick();
    cfg_wr = 1'b0;
  endtask

  task automatic enter();
    lp_req = 1'b1;
    tick();
    lp_req = 1'b0;
  endtask

  task automatic wake(input int bitn);
    irq_src[bitn] = 1'b1;
    tick();
    irq_src = '0;
  endtask

  // cycle index (from the current cycle, 0) of the first two cpu_ce pulses
  task automatic measure(input int limit, output int p1, output int p2);
    p1 = -1; p2 = -1;
    for (int k = 0; k < limit; k++) begin
      if (cpu_ce && lp_active) begin
        if (p1 < 0) p1 = k;
        else if (p2 < 0) p2 = k;
      end
      tick();
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int p1, p2, n, lows;
    tick(); tick(); tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk("R1 lp_active", int'(lp_active), 0);
    chk("R1 cpu_ce", int'(cpu_ce), 1);
    chk("R1 core_rst", int'(core_rst), 0);
    chk("R1 por_irq", int'(por_irq), 0);
    enter();
    chk("R1 default disabled", int'(lp_active), 0);

    // R3 explicit disable
    write_cfg(1'b0, 1'b0, 1'b0, 5'd3);
    enter();
    chk("R3 request ignored", int'(lp_active), 0);
    lows = 0;
    for (int k = 0; k < 6; k++) begin
      if (!cpu_ce) lows++;
      tick();
    end
    chk("R2 enable held high", lows, 0);

    // table walk: R4 / R5 periods, R7 gentle wake
    for (int i = 0; i < NV; i++) begin
      write_cfg(1'b1, 1'b0, V_PRE[i][0], V_DIV[i][4:0]);
      enter();
      chk("R3 entry", int'(lp_active), 1);
      measure(2 * V_PER[i] + 2, p1, p2);
      chk(V_PRE[i] != 0 ? "R5 first pulse" : "R4 first pulse", p1, V_PER[i] - 1);
      chk(V_PRE[i] != 0 ? "R5 second pulse" : "R4 second pulse", p2, 2 * V_PER[i] - 1);
      wake(i * 2);
      chk("R7 exit", int'(lp_active), 0);
      chk("R7 full rate", int'(cpu_ce), 1);
      chk("R7 no core reset", int'(core_rst), 0);
      chk("R7 por unchanged", int'(por_irq), 0);
    end

    // R6 reconfigure mid-period: T=4, write div=4 (T=10) in cycle 0
    write_cfg(1'b1, 1'b0, 1'b0, 5'd1);
    enter();
    cfg_en = 1'b1; cfg_destr = 1'b0; cfg_pre16 = 1'b0; cfg_div = 5'd4; cfg_wr = 1'b1;
    p1 = -1; p2 = -1;
    for (int k = 0; k < 16; k++) begin
      if (cpu_ce && lp_active) begin
        if (p1 < 0) p1 = k;
        else if (p2 < 0) p2 = k;
      end
      tick();
      cfg_wr = 1'b0;
    end
    chk("R6 old period kept", p1, 3);
    chk("R6 new period applied", p2, 13);
    wake(1);

    // R10 enable cleared during low power: T=4, exit after pulse in cycle 3
    write_cfg(1'b1, 1'b1, 1'b0, 5'd1);
    enter();
    write_cfg(1'b0, 1'b1, 1'b0, 5'd1);
    tick(); tick();
    chk("R10 still low at pulse", int'(lp_active && cpu_ce), 1);
    tick();
    chk("R10 exit", int'(lp_active), 0);
    chk("R10 no core reset", int'(core_rst), 0);

    // R8 hard recovery
    write_cfg(1'b1, 1'b1, 1'b0, 5'd2);
    enter();
    tick(); tick(); tick();
    wake(15);
    chk("R8 reset starts", int'(core_rst), 1);
    chk("R8 por low during reset", int'(por_irq), 0);
    n = 0; lows = 0;
    while (core_rst && n < 40) begin
      if (!cpu_ce) lows++;
      n++;
      tick();
    end
    chk("R8 reset length", n, 24);
    chk("R8 full rate in reset", lows, 0);
    chk("R8 por raised", int'(por_irq), 1);
    chk("R8 back to full", int'(lp_active), 0);

    // R9 hold and clear
    for (int k = 0; k < 5; k++) tick();
    chk("R9 por held", int'(por_irq), 1);
    por_clr = 1'b1;
    tick();
    por_clr = 1'b0;
    chk("R9 por cleared", int'(por_irq), 0);

    // R11 interrupts outside low power
    irq_src = '1;
    tick(); tick(); tick();
    irq_src = '0;
    chk("R11 no core reset", int'(core_rst), 0);
    chk("R11 no por", int'(por_irq), 0);
    chk("R11 stays full", int'(lp_active), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule